// File: doc/BRIEF.md
# Duty-Cycled Sampling Host for a Three-Wire Serial Converter

This block is the master side of a three-wire link to a successive-approximation converter. Working from the system clock, it drives an active-low select line and a divided serial clock, and it reads one 16-bit frame per conversion. From that frame it keeps only the data field: the four leading bits are dropped and the result is right-aligned for a resolution of 12, 10 or 8 bits. The result is presented together with a one-cycle valid strobe.

A request can run in one of two styles. In continuous style the host runs a single full frame, which leaves the converter powered. In burst style the host wakes the converter with a frame whose result is thrown away, then runs a second frame and reports it. It then ends a third frame early, after a set number of falling edges, which puts the converter back to sleep. Cycle counts held as parameters set the quiet gap between frames, the minimum high time of the select line and the delay from select to the first clock edge.

Top module: `adcBurstHost`

## Requirements
- R1: While reset is asserted, csN is 1, sclk is 0, busy is 0 and resultValid is 0.
- R2: sclk is 0 whenever csN is 1, and the first sclk edge after csN falls is a rising edge. That edge comes at least SETUP_CYC clocks after the fall, and every later high or low phase lasts exactly DIV_HALF clocks.
- R3: A full frame has exactly 16 sclk falling edges. The host samples sdataIn on each falling edge, and the first bit sampled is frame bit 15.
- R4: For a reported frame, result equals frame bits [11:12-RES_BITS], right-aligned. resultValid is a one-cycle pulse that comes DIV_HALF clocks after the 16th falling edge, on the same clock edge that raises csN. result does not change between pulses.
- R5: leadErr is updated together with resultValid. It is 1 when any of frame bits [15:12] was sampled as 1, and 0 otherwise.
- R6: When burstMode is 0, a request runs exactly one 16-edge frame and that frame is reported.
- R7: When burstMode is 1, a request runs three frames. The first has 16 edges and is not reported. The second has 16 edges and is reported. The third has exactly SLEEP_FALLS falling edges (a value from 2 to 10), after which csN rises. There is exactly one resultValid per request.
- R8: Between a rise of csN and its next fall, csN stays high for at least the larger of QUIET_CYC and CSPULSE_CYC clocks.
- R9: busy rises on the clock after a request is accepted. It stays high until the last quiet gap of the sequence has ended. A startReq that arrives while busy is 1 starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Request pulse that starts a sequence when the host is idle |
| burstMode | input | 1 | Style selector sampled with the request: 1 = wake/read/sleep burst, 0 = single frame |
| sdataIn | input | 1 | Serial data from the converter |
| csN | output | 1 | Active-low select that frames each conversion |
| sclk | output | 1 | Divided serial clock, parked low |
| busy | output | 1 | High while a sequence is running |
| result | output | RES_BITS | Right-aligned conversion result |
| resultValid | output | 1 | One-cycle strobe that marks a new result |
| leadErr | output | 1 | Set when a leading frame bit read as 1 |

## Verification
Two events share one clock edge: the capture of the result and the release of csN at the end of a frame. The bench's monitor times the result strobe against the 16th falling edge, requires that csN is already high when the strobe appears, and checks that the quiet gap is still counted in full from that same edge. A second overlap is a stray request that lands partway through a burst, with the opposite burstMode. It is judged by the frame count, the falling-edge count of each frame and the number of reported results, which must all match an undisturbed burst.

// File: rtl/adcHostPkg.sv
package adcHostPkg;
  localparam int FRAME_LEN = 16;
  localparam int LEAD_BITS = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_CLOCK, ST_GAP} hostState_t;
  typedef enum logic [1:0] {FR_DUMMY, FR_VALID, FR_SLEEP} frameKind_t;

  typedef struct packed {
    logic shiftEn;
    logic capture;
  } hostStrobes_t;
endpackage

// File: rtl/adcHostControl.sv
module adcHostControl
  import adcHostPkg::*;
#(
  parameter int DIV_HALF    = 2,
  parameter int QUIET_CYC   = 10,
  parameter int CSPULSE_CYC = 2,
  parameter int SETUP_CYC   = 2,
  parameter int SLEEP_FALLS = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startReq,
  input  logic         burstMode,
  output logic         csN,
  output logic         sclk,
  output logic         busy,
  output hostStrobes_t strobes
);
  localparam int GAP_CYC  = (QUIET_CYC > CSPULSE_CYC) ? QUIET_CYC : CSPULSE_CYC;
  localparam int WAIT_MAX = (GAP_CYC > SETUP_CYC) ? GAP_CYC : SETUP_CYC;
  localparam int WAIT_W   = $clog2(WAIT_MAX + 1);
  localparam int DIV_W    = $clog2(DIV_HALF + 1);
  localparam int FALL_W   = $clog2(FRAME_LEN + 1);
  localparam int GAP_W    = $clog2(GAP_CYC + 1);

  hostState_t          state;
  frameKind_t          kind;
  logic                burstLat;
  logic [WAIT_W-1:0]   waitCnt;
  logic [DIV_W-1:0]    divCnt;
  logic [FALL_W-1:0]   fallCnt;
  logic [FALL_W-1:0]   lastFalls;
  logic                haveNext;
  frameKind_t          nextKind;
  logic                divDone;

  always_comb begin
    lastFalls = (kind == FR_SLEEP) ? FALL_W'(SLEEP_FALLS) : FALL_W'(FRAME_LEN);
    haveNext  = (kind == FR_DUMMY) || (kind == FR_VALID && burstLat);
    nextKind  = (kind == FR_DUMMY) ? FR_VALID : FR_SLEEP;
    divDone   = (state == ST_CLOCK) && (divCnt == '0);
    strobes.shiftEn = divDone && sclk;
    strobes.capture = divDone && !sclk && (fallCnt == lastFalls) && (kind == FR_VALID);
    busy = (state != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      kind     <= FR_VALID;
      burstLat <= 1'b0;
      csN      <= 1'b1;
      sclk     <= 1'b0;
      waitCnt  <= '0;
      divCnt   <= '0;
      fallCnt  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (startReq) begin
            burstLat <= burstMode;
            kind     <= burstMode ? FR_DUMMY : FR_VALID;
            csN      <= 1'b0;
            waitCnt  <= WAIT_W'(SETUP_CYC - 1);
            fallCnt  <= '0;
            state    <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (waitCnt == '0) begin
            divCnt <= DIV_W'(DIV_HALF - 1);
            state  <= ST_CLOCK;
          end else begin
            waitCnt <= waitCnt - 1'b1;
          end
        end
        ST_CLOCK: begin
          if (divCnt != '0) begin
            divCnt <= divCnt - 1'b1;
          end else begin
            divCnt <= DIV_W'(DIV_HALF - 1);
            if (sclk) begin
              sclk    <= 1'b0;
              fallCnt <= fallCnt + 1'b1;
            end else if (fallCnt == lastFalls) begin
              csN     <= 1'b1;
              waitCnt <= WAIT_W'(GAP_CYC - 1);
              state   <= ST_GAP;
            end else begin
              sclk <= 1'b1;
            end
          end
        end
        ST_GAP: begin
          if (waitCnt != '0) begin
            waitCnt <= waitCnt - 1'b1;
          end else if (haveNext) begin
            kind    <= nextKind;
            csN     <= 1'b0;
            waitCnt <= WAIT_W'(SETUP_CYC - 1);
            fallCnt <= '0;
            state   <= ST_SETUP;
          end else begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Count of clocks the select line has spent high, saturating at the gap.
  logic [GAP_W-1:0] csHighCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              csHighCnt <= GAP_W'(GAP_CYC);
    else if (!csN)                          csHighCnt <= '0;
    else if (csHighCnt != GAP_W'(GAP_CYC))  csHighCnt <= csHighCnt + 1'b1;
  end

  assert_quiet_gap_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> (csHighCnt >= GAP_W'(GAP_CYC)));

  assert_sclk_parked_R2: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (csN && !sclk));

  assert_fall_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    fallCnt <= FALL_W'(FRAME_LEN));
endmodule

// File: rtl/adcHostDatapath.sv
module adcHostDatapath
  import adcHostPkg::*;
#(
  parameter int RES_BITS = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  hostStrobes_t        strobes,
  input  logic                sdataIn,
  output logic [RES_BITS-1:0] result,
  output logic                resultValid,
  output logic                leadErr
);
  localparam int DATA_TOP = FRAME_LEN - LEAD_BITS - 1;

  logic [FRAME_LEN-1:0] frameReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameReg    <= '0;
      result      <= '0;
      resultValid <= 1'b0;
      leadErr     <= 1'b0;
    end else begin
      if (strobes.shiftEn) frameReg <= {frameReg[FRAME_LEN-2:0], sdataIn};
      resultValid <= strobes.capture;
      if (strobes.capture) begin
        result  <= frameReg[DATA_TOP -: RES_BITS];
        leadErr <= |frameReg[FRAME_LEN-1 -: LEAD_BITS];
      end
    end
  end

  assert_result_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !resultValid |-> $stable(result));

  assert_valid_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);
endmodule

// File: rtl/adcBurstHost.sv
module adcBurstHost
  import adcHostPkg::*;
#(
  parameter int RES_BITS    = 12,
  parameter int DIV_HALF    = 2,
  parameter int QUIET_CYC   = 10,
  parameter int CSPULSE_CYC = 2,
  parameter int SETUP_CYC   = 2,
  parameter int SLEEP_FALLS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startReq,
  input  logic                burstMode,
  input  logic                sdataIn,
  output logic                csN,
  output logic                sclk,
  output logic                busy,
  output logic [RES_BITS-1:0] result,
  output logic                resultValid,
  output logic                leadErr
);
  hostStrobes_t strobes;

  adcHostControl #(
    .DIV_HALF(DIV_HALF), .QUIET_CYC(QUIET_CYC), .CSPULSE_CYC(CSPULSE_CYC),
    .SETUP_CYC(SETUP_CYC), .SLEEP_FALLS(SLEEP_FALLS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .burstMode(burstMode),
    .csN(csN), .sclk(sclk), .busy(busy), .strobes(strobes)
  );

  adcHostDatapath #(.RES_BITS(RES_BITS)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .sdataIn(sdataIn),
    .result(result), .resultValid(resultValid), .leadErr(leadErr)
  );
endmodule

// File: tb/adcBurstHost_tb.sv
`timescale 1ns/100ps
module adcBurstHost_tb;
  localparam int RES = 8, DIV = 2, QUIET = 5, PULSE = 3, SETUP = 2, SLEEP = 4;
  localparam int GAP = (QUIET > PULSE) ? QUIET : PULSE;

  logic clk = 1'b0, rstN = 1'b0, startReq = 1'b0, burstMode = 1'b0;
  logic csN, sclk, sdata, busy, resultValid, leadErr;
  logic [RES-1:0] result;
  int checks = 0, failures = 0, cycles = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cycles++;

  adcBurstHost #(.RES_BITS(RES), .DIV_HALF(DIV), .QUIET_CYC(QUIET), .CSPULSE_CYC(PULSE),
    .SETUP_CYC(SETUP), .SLEEP_FALLS(SLEEP)) u_dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .burstMode(burstMode), .sdataIn(sdata),
    .csN(csN), .sclk(sclk), .busy(busy), .result(result), .resultValid(resultValid),
    .leadErr(leadErr));

  // Converter model: bit 15 at the select fall, next bit after each sclk fall.
  logic [15:0] goodWord = '0, dummyWord = '0, devWord = '0;
  bit seqBurst = 1'b0;
  int devFalls = 0, devBase = 0, devCsFalls = 0, seqStart = 0;
  always @(negedge sclk) begin #1; devFalls++; end
  always @(negedge csN) begin
    devCsFalls++;
    devBase = devFalls;
    devWord = (seqBurst && (devCsFalls - seqStart == 1)) ? dummyWord : goodWord;
  end
  assign sdata = ((devFalls - devBase) < 16) ? devWord[15 - (devFalls - devBase)] : 1'b0;

  // Port monitor sampled away from the active edge.
  logic prevCs = 1'b1, prevSclk = 1'b0;
  bit sawEdge = 1'b0;
  int gapCnt = 1000, setupCnt = 0, phaseCnt = 0, curFalls = 0, monFrames = 0, sinceFall = 0;
  int fallsLog [8];
  int rvTotal = 0, rvFrame = 0;
  logic [RES-1:0] lastRes = '0;
  logic lastLead = 1'b0;
  int gapViol = 0, setupViol = 0, phaseViol = 0, edgeViol = 0, rvViol = 0;

  always @(negedge clk) if (rstN) begin
    sinceFall++;
    if (prevCs && !csN) begin
      if (gapCnt < GAP) gapViol++;
      gapCnt = 0; monFrames++; curFalls = 0; setupCnt = 0; sawEdge = 0; phaseCnt = 0;
    end
    if (!prevCs && csN) fallsLog[(monFrames - 1) % 8] = curFalls;
    if (csN) begin
      gapCnt++;
      if (sclk) edgeViol++;
    end else begin
      if (sclk != prevSclk) begin
        if (!sawEdge) begin
          if (!sclk) edgeViol++;
          if (setupCnt < SETUP) setupViol++;
        end else if (phaseCnt != DIV) phaseViol++;
        sawEdge = 1; phaseCnt = 1;
        if (!sclk) begin curFalls++; sinceFall = 0; end
      end else begin
        phaseCnt++;
        if (!sawEdge) setupCnt++;
      end
    end
    if (resultValid) begin
      rvTotal++; rvFrame = monFrames; lastRes = result; lastLead = leadErr;
      if (!csN || sinceFall != DIV) rvViol++;
    end
    prevCs = csN; prevSclk = sclk;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runSeq(input bit burst, input logic [3:0] lead, input logic [RES-1:0] data,
                        input logic [15:0] dummy, input bit poke, input string req);
    int f0, r0, nFrames;
    goodWord = {lead, data, {(16 - 4 - RES){1'b0}}};
    dummyWord = dummy; seqBurst = burst; seqStart = devCsFalls;
    f0 = monFrames; r0 = rvTotal;
    @(negedge clk); startReq = 1'b1; burstMode = burst;
    @(negedge clk); startReq = 1'b0;
    if (poke) check("R9 busy after request", int'(busy), 1);
    if (poke) begin
      repeat (40) @(negedge clk);
      startReq = 1'b1; burstMode = !burst;
      @(negedge clk); startReq = 1'b0; burstMode = burst;
    end
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    nFrames = monFrames - f0;
    check({req, " frames"}, nFrames, burst ? 3 : 1);
    check({req, " R3 falls frame0"}, fallsLog[f0 % 8], 16);
    if (burst) begin
      check({req, " R7 falls valid"}, fallsLog[(f0 + 1) % 8], 16);
      check({req, " R7 falls sleep"}, fallsLog[(f0 + 2) % 8], SLEEP);
    end
    check({req, " results"}, rvTotal - r0, 1);
    check({req, " reported frame"}, rvFrame - f0, burst ? 2 : 1);
    check({req, " R4 data"}, int'(lastRes), int'(data));
    check({req, " R5 lead flag"}, int'(lastLead), (lead != 4'b0) ? 1 : 0);
  endtask

  initial begin
    wait (cycles >= 150000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=<150000", cycles);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 csN", int'(csN), 1);
    check("R1 sclk", int'(sclk), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 resultValid", int'(resultValid), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    for (int v = 0; v < (1 << RES); v++)
      runSeq(1'b0, 4'b0000, RES'(v), 16'h0000, 1'b0, "R6 single");

    runSeq(1'b1, 4'b0000, 8'hA5, 16'hFFFF, 1'b0, "R7 burst");
    runSeq(1'b1, 4'b0000, 8'h00, 16'hFFFF, 1'b0, "R7 burst zero");
    runSeq(1'b1, 4'b0000, 8'hFF, 16'h0FF0, 1'b0, "R7 burst full");
    runSeq(1'b0, 4'b1000, 8'h3C, 16'h0000, 1'b0, "R5 lead msb");
    runSeq(1'b0, 4'b0001, 8'hC3, 16'h0000, 1'b0, "R5 lead lsb");
    runSeq(1'b0, 4'b0000, 8'h5A, 16'h0000, 1'b0, "R5 lead clear");
    runSeq(1'b1, 4'b0000, 8'h69, 16'hFFFF, 1'b1, "R9 poke burst");
    runSeq(1'b0, 4'b0000, 8'h96, 16'h0000, 1'b1, "R9 poke single");

    check("R2 first edge rising and parked low", edgeViol, 0);
    check("R2 setup before first edge", setupViol, 0);
    check("R2 phase length", phaseViol, 0);
    check("R4 strobe timing", rvViol, 0);
    check("R8 quiet gap", gapViol, 0);
    check("R9 idle at end busy", int'(busy), 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule